// File: doc/BRIEF.md
# Bus Interrupt Requester with Acknowledge Release

This block raises one interrupt request on a shared backplane that has seven prioritized request lines. Software first programs a configuration register with the request level (1 to 7) and an 8-bit status/ID vector. A write of any value to a fire register then pulls the line for that level low. The line stays low until an interrupt-acknowledge cycle arrives for that same level. On that cycle the block returns the stored vector on an 8-bit response and releases the line.

A debug cancel register lets software drop a stuck request without any acknowledge. While a request is outstanding, the configuration is frozen, so the vector returned always belongs to the level that was asserted. A busy output shows whether a request is outstanding.

The register port decodes a 2-bit address: 0 is configuration, 1 is fire, 2 is debug cancel, and 3 is unused.

Top module: `irq_raiser`

## Requirements
- R1: After reset all seven request outputs are high, `busy` is 0, `vec_valid` is 0 and `vec_data` is 0. The stored level is 0.
- R2: A write to address 0 stores the vector from `wr_data[7:0]` and the level from `wr_data[10:8]`; all other data bits are ignored. A write to address 3 changes nothing.
- R3: A write to address 1 while idle, with a stored level L from 1 to 7, makes `busy` 1 and drives `irq_n[L-1]` low from the next cycle on, whatever the write data. At most one request line is ever low.
- R4: If the stored level is 0, a write to address 1 leaves every line high and `busy` at 0.
- R5: An outstanding request stays asserted until it is acknowledged or cancelled.
- R6: When `iack_valid` is 1 and `iack_level` equals the outstanding level, the next cycle shows `vec_valid` 1 for exactly one cycle with `vec_data` equal to the stored vector. In that same cycle every line is high and `busy` is 0.
- R7: An acknowledge for any other level, or one given while idle, is ignored: `vec_valid` stays 0, `vec_data` stays 0 and the request is unchanged.
- R8: A write to address 2 with `wr_data[0]`=1 releases the request in the next cycle and returns no vector. With `wr_data[0]`=0 the write has no effect.
- R9: A write to address 1 while a request is outstanding has no effect.
- R10: A write to address 0 while a request is outstanding is ignored. The later acknowledge returns the vector that was stored before the fire.
- R11: If a matching acknowledge and a debug cancel arrive in the same cycle, the vector is still returned and the request is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 config, 1 fire, 2 debug cancel, 3 unused |
| wr_data | input | 16 | Register write data |
| iack_valid | input | 1 | Interrupt-acknowledge cycle present |
| iack_level | input | 3 | Level being acknowledged |
| irq_n | output | 7 | Active-low request lines; bit i is level i+1 |
| vec_valid | output | 1 | One-cycle strobe: vector returned |
| vec_data | output | 8 | Returned vector; 0 when not valid |
| busy | output | 1 | A request is outstanding |

## Verification
The assertions take for granted that `iack_level` is meaningful only while `iack_valid` is high. They also assume the register port carries at most one write per cycle, which the single write strobe enforces. The stimulus drives every input half a cycle away from the active edge. It mixes random register writes and random acknowledge levels with acknowledges aimed at the outstanding level, so hits, misses, cancels and frozen-configuration writes all occur. Acknowledge levels cover the full 3-bit range, including 0, which never matches.

// File: rtl/irq_raiser_pkg.sv
package irq_raiser_pkg;

  // Register select decoded from the write address.
  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_FIRE   = 2'd1,
    SEL_CANCEL = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_RAISED = 1'b1
  } req_state_e;

  // Returns 1 when a level selects a real request line.
  function automatic logic level_usable(input int unsigned lvl, input int unsigned lines);
    return (lvl != 0) && (lvl <= lines);
  endfunction

  // Returns 1 when line index idx (0-based) carries level lvl.
  function automatic logic line_selected(input int unsigned idx, input int unsigned lvl);
    return (lvl == idx + 1);
  endfunction

  // Returns 1 when an acknowledge cycle addresses the outstanding request.
  function automatic logic ack_matches(input logic raised, input logic ack_v,
                                       input int unsigned ack_lvl, input int unsigned cur_lvl);
    return raised && ack_v && (ack_lvl == cur_lvl);
  endfunction

endpackage

// File: rtl/irq_raiser_regs.sv
module irq_raiser_regs
  import irq_raiser_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned LVL_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [LVL_W-1:0]  cfg_lvl,
  output logic [VEC_W-1:0]  cfg_vec,
  output logic              fire_evt,
  output logic              cancel_evt
);

  localparam int unsigned LVL_MSB = LVL_LSB + LVL_W - 1;

  reg_sel_e sel;
  logic     cfg_load;

  assign sel        = reg_sel_e'(wr_addr[1:0]);
  assign fire_evt   = wr_en && (sel == SEL_FIRE);
  assign cancel_evt = wr_en && (sel == SEL_CANCEL) && wr_data[0];
  assign cfg_load   = wr_en && (sel == SEL_CFG) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_lvl <= '0;
      cfg_vec <= '0;
    end else if (cfg_load) begin
      cfg_lvl <= wr_data[LVL_MSB:LVL_LSB];
      cfg_vec <= wr_data[VEC_W-1:0];
    end
  end

  // R10: configuration frozen while a request is outstanding
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg_lvl) && $stable(cfg_vec)));

  // R2: a config write while idle lands in the register
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 0 && !busy) |=> (cfg_vec == $past(wr_data[VEC_W-1:0])));

endmodule

// File: rtl/irq_raiser_core.sv
module irq_raiser_core
  import irq_raiser_pkg::*;
#(
  parameter int unsigned NUM_LINES = 7,
  parameter int unsigned LVL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_evt,
  input  logic             cancel_evt,
  input  logic [LVL_W-1:0] cfg_lvl,
  input  logic             iack_valid,
  input  logic [LVL_W-1:0] iack_level,
  output logic             busy,
  output logic             ack_hit,
  output logic             raise_evt
);

  req_state_e state, state_nx;

  assign busy      = (state == ST_RAISED);
  assign ack_hit   = ack_matches(busy, iack_valid, int'(iack_level), int'(cfg_lvl));
  assign raise_evt = !busy && fire_evt && level_usable(int'(cfg_lvl), NUM_LINES);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (raise_evt) state_nx = ST_RAISED;
      ST_RAISED: if (ack_hit || cancel_evt) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R3: a fire while idle with a usable level raises the request
  p_fire_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt && !busy && cfg_lvl != 0) |=> busy);

  // R4: level 0 never raises
  p_level0_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_lvl == 0) |=> !busy);

  // R5: request held until acknowledge or cancel
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ack_hit && !cancel_evt) |=> busy);

  // R6: matching acknowledge releases
  p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !busy);

  // R8: debug cancel releases
  p_cancel_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !busy);

endmodule

// File: rtl/irq_raiser_drive.sv
module irq_raiser_drive
  import irq_raiser_pkg::*;
#(
  parameter int unsigned NUM_LINES = 7,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned VEC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busy,
  input  logic                 ack_hit,
  input  logic                 iack_valid,
  input  logic [LVL_W-1:0]     cfg_lvl,
  input  logic [VEC_W-1:0]     cfg_vec,
  output logic [NUM_LINES-1:0] irq_n,
  output logic                 vec_valid,
  output logic [VEC_W-1:0]     vec_data
);

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    assign irq_n[gi] = !(busy && line_selected(gi, int'(cfg_lvl)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= ack_hit;
      vec_data  <= ack_hit ? cfg_vec : '0;
    end
  end

  // R3: never more than one line low
  p_one_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~irq_n));

  // R5: a busy block drives exactly one line
  p_busy_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~irq_n) == 1));

  // R6: a hit returns the stored vector and leaves all lines high
  p_vec_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> (vec_valid && vec_data == $past(cfg_vec) && irq_n == '1));

  // R7: an acknowledge that misses produces no vector
  p_miss_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_valid && !ack_hit) |=> (!vec_valid && vec_data == '0));

  // R6: the vector strobe lasts one cycle
  p_strobe_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

endmodule

// File: rtl/irq_raiser.sv
module irq_raiser
  import irq_raiser_pkg::*;
#(
  parameter int unsigned NUM_LINES = 7,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned LVL_LSB   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          iack_valid,
  input  logic [$clog2(NUM_LINES+1)-1:0] iack_level,
  output logic [NUM_LINES-1:0]          irq_n,
  output logic                          vec_valid,
  output logic [VEC_W-1:0]              vec_data,
  output logic                          busy
);

  localparam int unsigned LVL_W = $clog2(NUM_LINES + 1);

  logic [LVL_W-1:0] cfg_lvl;
  logic [VEC_W-1:0] cfg_vec;
  logic             fire_evt;
  logic             cancel_evt;
  logic             ack_hit;
  logic             raise_evt;

  irq_raiser_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .VEC_W(VEC_W), .LVL_LSB(LVL_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .cfg_lvl(cfg_lvl), .cfg_vec(cfg_vec),
    .fire_evt(fire_evt), .cancel_evt(cancel_evt)
  );

  irq_raiser_core #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_core (
    .clk(clk), .rst_n(rst_n), .fire_evt(fire_evt), .cancel_evt(cancel_evt),
    .cfg_lvl(cfg_lvl), .iack_valid(iack_valid), .iack_level(iack_level),
    .busy(busy), .ack_hit(ack_hit), .raise_evt(raise_evt)
  );

  irq_raiser_drive #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ack_hit(ack_hit), .iack_valid(iack_valid),
    .cfg_lvl(cfg_lvl), .cfg_vec(cfg_vec),
    .irq_n(irq_n), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  // R3: a raise event shows up on the lines one cycle later
  p_raise_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> (irq_n != '1));

  // R11: acknowledge wins the vector even when cancelled in the same cycle
  p_ack_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && fire_evt == 1'b0 && wr_en && wr_addr == 2 && wr_data[0]) |=> (vec_valid && !busy));

endmodule

// File: tb/sim_irq_raiser.sv
module sim_irq_raiser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [6:0]  irq_n;
  logic        vec_valid;
  logic [7:0]  vec_data;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  bit       m_pend = 0;
  int       m_lvl = 0;
  int       m_vec = 0;
  bit       m_vv = 0;
  int       m_vd = 0;

  always #4 clk = ~clk;

  irq_raiser u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .iack_valid(iack_valid), .iack_level(iack_level),
    .irq_n(irq_n), .vec_valid(vec_valid), .vec_data(vec_data), .busy(busy)
  );

  function automatic logic [6:0] exp_lines(bit pend, int lvl);
    logic [6:0] v = 7'h7f;
    for (int k = 1; k <= 7; k++)
      if (pend && k == lvl) v = v & ~(7'h01 << (k - 1));
    return v;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "irq_n", int'(irq_n), int'(exp_lines(m_pend, m_lvl)));
    check(tag, "busy", int'(busy), int'(m_pend));
    check(tag, "vec_valid", int'(vec_valid), int'(m_vv));
    check(tag, "vec_data", int'(vec_data), m_vd);
  endtask

  // One cycle: drive at a falling edge, advance the model, compare at the next falling edge.
  task automatic step(bit we, int addr, int data, bit av, int al, string tag);
    bit hit;
    wr_en = we; wr_addr = 2'(addr); wr_data = 16'(data);
    iack_valid = av; iack_level = 3'(al);
    hit = av && m_pend && (al == m_lvl);
    m_vv = hit;
    m_vd = hit ? m_vec : 0;
    if (hit || (we && addr == 2 && data[0])) m_pend = 0;
    else if (we && addr == 1 && !m_pend && m_lvl != 0) m_pend = 1;
    else if (we && addr == 0 && !m_pend) begin
      m_lvl = (data >> 8) & 7;
      m_vec = data & 8'hff;
    end
    @(negedge clk);
    wr_en = 0; iack_valid = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    // R4: level 0 after reset: fire does nothing
    step(1, 1, 16'hffff, 0, 0, "R4");
    // R2: spare address ignored, then config level 3 vector A5 with noise bits
    step(1, 3, 16'h07aa, 0, 0, "R2");
    step(1, 0, 16'hf3a5, 0, 0, "R2");
    // R3: fire with arbitrary data
    step(1, 1, 16'h1234, 0, 0, "R3");
    // R7: wrong level, level 0, no valid
    step(0, 0, 0, 1, 5, "R7");
    step(0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 3, "R5");
    // R9: fire again while pending
    step(1, 1, 16'h0000, 0, 0, "R9");
    // R10: config while pending ignored
    step(1, 0, 16'h0611, 0, 0, "R10");
    // R8: cancel with bit0=0 no effect
    step(1, 2, 16'hfffe, 0, 0, "R8");
    // R6: matching ack returns A5
    step(0, 0, 0, 1, 3, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R7: ack while idle
    step(0, 0, 0, 1, 3, "R7");
    // R8: cancel path, level 7
    step(1, 0, 16'h073c, 0, 0, "R2");
    step(1, 1, 16'h0, 0, 0, "R3");
    step(1, 2, 16'h0001, 0, 0, "R8");
    step(0, 0, 0, 1, 7, "R7");
    // R11: ack and cancel together, level 1
    step(1, 0, 16'h0181, 0, 0, "R2");
    step(1, 1, 16'h5555, 0, 0, "R3");
    step(1, 2, 16'h0001, 1, 1, "R11");
    step(0, 0, 0, 0, 0, "R11");

    // random phase
    for (int n = 0; n < 2000; n++) begin
      int op = $urandom % 10;
      int d = $urandom & 16'hffff;
      bit we = 1;
      int a = 0;
      bit av;
      int al;
      if (op < 3) a = 0;
      else if (op < 5) a = 1;
      else if (op == 5) a = 2;
      else if (op == 6) a = 3;
      else we = 0;
      av = ($urandom % 5) < 2;
      al = ($urandom % 2) ? m_lvl : ($urandom % 8);
      step(we, a, d, av, al, "R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule